// File: doc/BRIEF.md
# Packet CRC-32 Checker

This receive-side block watches a byte-wide character stream in which every byte carries a control flag and a valid strobe. It finds packet boundaries from a start delimiter and an end delimiter. Each delimiter is a control character whose code comes from one of three fixed protocol presets, or from two programmable codes when user mode is selected. Between the delimiters it recomputes a 32-bit CRC over the payload. The last four payload bytes before the end delimiter are the transmitted check value, so they are left out of the recomputation.

Packet length is not known in advance. For that reason the datapath holds the newest four payload bytes in a shift buffer, and a byte is folded into the running CRC only once four newer payload bytes have arrived behind it. When an end delimiter arrives, the buffer holds the received check value and the register holds the CRC of everything before it. The block then reports a single-cycle verdict. Decoding and disparity checking are done elsewhere.

Top module: `pktCrcCheck`

## Requirements
- R1: While reset is held and after it is released, crcDone and crcError are low until the first end delimiter is accepted.
- R2: The CRC uses the reflected polynomial 0xEDB88320, with the register set to all ones at every start delimiter. It is updated least significant bit first. The complement of the final register must equal the four bytes before the end delimiter, where the earliest of them is the least significant byte. A packet that meets this rule gives crcDone high with crcError low.
- R3: A packet in which any single bit of the payload or of the check bytes is inverted gives crcDone high with crcError high. crcError is never high without crcDone.
- R4: crcDone is high for exactly one cycle. That cycle is the one following the clock edge that accepts the end delimiter.
- R5: An end delimiter that arrives while no packet is open gives crcDone with crcError high.
- R6: An end delimiter that arrives after fewer than four payload bytes gives crcDone with crcError high.
- R7: A start delimiter that arrives while a packet is open discards the partial packet and restarts the computation.
- R8: A delimiter is recognised only when the control flag is high. The codes (SOP/EOP) are 0xFB/0xFD for mode 0, 0x5C/0x7C for mode 1 and 0x3C/0xDC for mode 2. Mode 3 uses the userSop and userEop inputs. A data byte whose value equals a delimiter code is ordinary payload.
- R9: A cycle with inValid low has no effect, whatever its data and flag.
- R10: A valid control character inside a packet that is neither the active start code nor the active end code is skipped and does not enter the payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inByte | input | 8 | Received character |
| inCtrl | input | 1 | High when inByte is a control character |
| inValid | input | 1 | Character strobe |
| modeSel | input | 2 | Delimiter preset: 0, 1, 2 fixed, 3 user |
| userSop | input | 8 | Start code used in mode 3 |
| userEop | input | 8 | End code used in mode 3 |
| crcDone | output | 1 | One-cycle pulse per end delimiter |
| crcError | output | 1 | Failure flag, valid with crcDone |

## Verification
The assertions check the cycle-level rules on every cycle:
- a start delimiter reloads all ones and empties the buffer;
- idle cycles leave the CRC and fill state untouched;
- the fill never exceeds four;
- every accepted end delimiter yields crcDone on the next cycle;
- an orphan end delimiter raises crcError;
- crcError never appears without crcDone.

Whether the verdict is right for real data can only be shown by the bench. It computes reference CRCs with a forward-polynomial model and sweeps the following:
- payload lengths in every mode;
- every single-bit corruption of one packet;
- short packets and restarted packets;
- gaps and stray control characters;
- data bytes that look like delimiters.

// File: rtl/pktCrcPkg.sv
package pktCrcPkg;

  typedef enum logic [1:0] {
    MODE_LAN    = 2'd0,
    MODE_STORE  = 2'd1,
    MODE_FABRIC = 2'd2,
    MODE_USER   = 2'd3
  } delimMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;   // start of packet: reload CRC, empty buffer
    logic push;    // payload byte accepted
    logic check;   // end of packet reached
  } crcStb_t;

endpackage

// File: rtl/pktCrcData.sv
module pktCrcData
  import pktCrcPkg::*;
#(
  parameter int CRC_W  = 32,
  parameter int BYTE_W = 8,
  parameter logic [CRC_W-1:0] POLY = 32'hEDB88320
) (
  input  logic              clk,
  input  logic              rstN,
  input  crcStb_t           stb,
  input  logic [BYTE_W-1:0] dataByte,
  output logic              holdFull,
  output logic              crcMatch
);

  localparam int HOLD   = CRC_W / BYTE_W;
  localparam int FILL_W = $clog2(HOLD + 1);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(HOLD);

  logic [CRC_W-1:0]  crcReg;
  logic [FILL_W-1:0] fill;
  logic [BYTE_W-1:0] holdBuf [HOLD];
  logic [CRC_W-1:0]  rxVal;

  function automatic logic [CRC_W-1:0] crcStep(logic [CRC_W-1:0] c, logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int b = 0; b < BYTE_W; b++) begin
      if (r[0] ^ d[b]) r = (r >> 1) ^ POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

  // running CRC and fill count
  always_ff @(posedge clk) begin
    if (!rstN || stb.clear) begin
      crcReg <= '1;
      fill   <= '0;
    end else if (stb.push) begin
      if (fill == FILL_MAX) crcReg <= crcStep(crcReg, holdBuf[HOLD-1]);
      else                  fill   <= fill + 1'b1;
    end
  end

  // shift buffer, index 0 holds the newest byte
  generate
    for (genvar i = 0; i < HOLD; i++) begin : g_hold
      always_ff @(posedge clk) begin
        if (!rstN) holdBuf[i] <= '0;
        else if (stb.push) holdBuf[i] <= (i == 0) ? dataByte : holdBuf[(i == 0) ? 0 : i-1];
      end
      // oldest buffered byte is the least significant byte of the check value
      assign rxVal[BYTE_W*i +: BYTE_W] = holdBuf[HOLD-1-i];
    end
  endgenerate

  assign holdFull = (fill == FILL_MAX);
  assign crcMatch = (rxVal == ~crcReg);

  a_r2_clear_init: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> (crcReg == '1 && fill == '0));
  a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.clear && !stb.push) |=> ($stable(crcReg) && $stable(fill)));
  a_r6_fill_bound: assert property (@(posedge clk) disable iff (!rstN)
    fill <= FILL_MAX);

endmodule

// File: rtl/pktCrcCtrl.sv
module pktCrcCtrl
  import pktCrcPkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] inByte,
  input  logic              inCtrl,
  input  logic              inValid,
  input  logic [1:0]        modeSel,
  input  logic [BYTE_W-1:0] userSop,
  input  logic [BYTE_W-1:0] userEop,
  input  logic              holdFull,
  input  logic              crcMatch,
  output crcStb_t           stb,
  output logic              crcDone,
  output logic              crcError
);

  logic [BYTE_W-1:0] sopCode, eopCode;
  logic isSop, isEop, inPkt;

  always_comb begin
    unique case (delimMode_t'(modeSel))
      MODE_LAN:    begin sopCode = BYTE_W'(8'hFB); eopCode = BYTE_W'(8'hFD); end
      MODE_STORE:  begin sopCode = BYTE_W'(8'h5C); eopCode = BYTE_W'(8'h7C); end
      MODE_FABRIC: begin sopCode = BYTE_W'(8'h3C); eopCode = BYTE_W'(8'hDC); end
      default:     begin sopCode = userSop;        eopCode = userEop;        end
    endcase
  end

  assign isSop = inValid && inCtrl && (inByte == sopCode);
  assign isEop = inValid && inCtrl && (inByte == eopCode) && !isSop;

  always_comb begin
    stb.clear = isSop;
    stb.push  = inValid && !inCtrl && inPkt;
    stb.check = isEop;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inPkt    <= 1'b0;
      crcDone  <= 1'b0;
      crcError <= 1'b0;
    end else begin
      if (isSop)      inPkt <= 1'b1;
      else if (isEop) inPkt <= 1'b0;
      crcDone  <= stb.check;
      crcError <= stb.check && (!inPkt || !holdFull || !crcMatch);
    end
  end

  a_r4_done_after_eop: assert property (@(posedge clk) disable iff (!rstN)
    isEop |=> crcDone);
  a_r5_orphan_eop: assert property (@(posedge clk) disable iff (!rstN)
    (isEop && !inPkt) |=> crcError);
  a_r3_error_needs_done: assert property (@(posedge clk) disable iff (!rstN)
    crcError |-> crcDone);
  a_r7_sop_opens: assert property (@(posedge clk) disable iff (!rstN)
    isSop |=> inPkt);

endmodule

// File: rtl/pktCrcCheck.sv
module pktCrcCheck
  import pktCrcPkg::*;
#(
  parameter int CRC_W  = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] inByte,
  input  logic              inCtrl,
  input  logic              inValid,
  input  logic [1:0]        modeSel,
  input  logic [BYTE_W-1:0] userSop,
  input  logic [BYTE_W-1:0] userEop,
  output logic              crcDone,
  output logic              crcError
);

  crcStb_t stb;
  logic holdFull, crcMatch;

  pktCrcCtrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inByte(inByte), .inCtrl(inCtrl), .inValid(inValid),
    .modeSel(modeSel), .userSop(userSop), .userEop(userEop),
    .holdFull(holdFull), .crcMatch(crcMatch), .stb(stb),
    .crcDone(crcDone), .crcError(crcError)
  );

  pktCrcData #(.CRC_W(CRC_W), .BYTE_W(BYTE_W)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .dataByte(inByte),
    .holdFull(holdFull), .crcMatch(crcMatch)
  );

endmodule

// File: tb/pktCrcCheck_test.sv
module pktCrcCheck_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] inByte = '0;
  logic inCtrl = 1'b0;
  logic inValid = 1'b0;
  logic [1:0] modeSel = '0;
  logic [7:0] userSop = 8'hA5;
  logic [7:0] userEop = 8'h5A;
  logic crcDone, crcError;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;   // 250 MHz

  pktCrcCheck uut (
    .clk(clk), .rstN(rstN), .inByte(inByte), .inCtrl(inCtrl), .inValid(inValid),
    .modeSel(modeSel), .userSop(userSop), .userEop(userEop),
    .crcDone(crcDone), .crcError(crcError)
  );

  function automatic logic [7:0] sopOf(int m);
    case (m)
      0: return 8'hFB;
      1: return 8'h5C;
      2: return 8'h3C;
      default: return userSop;
    endcase
  endfunction

  function automatic logic [7:0] eopOf(int m);
    case (m)
      0: return 8'hFD;
      1: return 8'h7C;
      2: return 8'hDC;
      default: return userEop;
    endcase
  endfunction

  // forward-form CRC on an LSB-first bit stream, bit-reversed and complemented at the end
  function automatic logic [31:0] refCrc(logic [7:0] d [64], int n);
    logic [31:0] r = '1;
    logic [31:0] o;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = r[31] ^ d[i][b];
        r = {r[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
      end
    for (int k = 0; k < 32; k++) o[k] = r[31-k];
    return ~o;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic putChar(logic [7:0] b, logic c);
    @(negedge clk);
    inByte = b; inCtrl = c; inValid = 1'b1;
  endtask

  task automatic putIdle();
    @(negedge clk);
    inValid = 1'b0; inByte = 8'hFD; inCtrl = 1'b1;
  endtask

  // after EOP was driven: verdict next negedge, then pulse must drop
  task automatic verdict(string req, logic expErr);
    @(negedge clk);
    inValid = 1'b0; inCtrl = 1'b0;
    check({req, " done"}, 32'(crcDone), 32'd1);
    check({req, " error"}, 32'(crcError), 32'(expErr));
    @(negedge clk);
    check("R4 done single cycle", 32'(crcDone), 32'd0);
  endtask

  // payload len bytes + 4 CRC bytes; optional single bit flip at flipPos
  task automatic sendPkt(string req, int mode, int len, int seed, int flipPos, int flipBit,
                         bit gappy, bit fakeEop);
    logic [7:0] pkt [64];
    logic [31:0] c;
    modeSel = 2'(mode);
    for (int i = 0; i < 64; i++) pkt[i] = 8'((seed * 37 + i * 13 + 7) & 8'hFF);
    if (fakeEop && len > 0) pkt[0] = eopOf(mode);
    c = refCrc(pkt, len);
    for (int k = 0; k < 4; k++) pkt[len + k] = c[8*k +: 8];
    if (flipPos >= 0) pkt[flipPos][flipBit] = ~pkt[flipPos][flipBit];
    putChar(sopOf(mode), 1'b1);
    for (int i = 0; i < len + 4; i++) begin
      putChar(pkt[i], 1'b0);
      if (gappy) begin
        putIdle();
        putChar(8'hF7, 1'b1);
      end
    end
    putChar(eopOf(mode), 1'b1);
    verdict(req, flipPos >= 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset done", 32'(crcDone), 32'd0);
    check("R1 reset error", 32'(crcError), 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle done", 32'(crcDone), 32'd0);

    // R2 R8: good packets of many lengths in every mode
    for (int m = 0; m < 4; m++)
      for (int len = 0; len <= 12; len++)
        sendPkt("R2 R8 good packet", m, len, m * 16 + len, -1, 0, 1'b0, 1'b0);

    // R3: every single-bit corruption of one packet
    for (int p = 0; p < 9; p++)
      for (int b = 0; b < 8; b++)
        sendPkt("R3 bit flip", p % 4, 5, 3, p, b, 1'b0, 1'b0);

    // R9 R10: idle gaps and stray control characters
    for (int m = 0; m < 4; m++)
      sendPkt("R9 R10 gaps and strays", m, 6, 40 + m, -1, 0, 1'b1, 1'b0);
    sendPkt("R9 R10 gaps with flip", 1, 6, 44, 2, 5, 1'b1, 1'b0);

    // R8: data byte equal to the EOP code is payload
    for (int m = 0; m < 4; m++)
      sendPkt("R8 data looks like EOP", m, 5, 50 + m, -1, 0, 1'b0, 1'b1);

    // R5: orphan EOP
    modeSel = 2'd0;
    putChar(8'hFD, 1'b1);
    verdict("R5 orphan EOP", 1'b1);

    // R6: fewer than four payload bytes
    for (int k = 0; k < 4; k++) begin
      modeSel = 2'd2;
      putChar(8'h3C, 1'b1);
      for (int i = 0; i < k; i++) putChar(8'(i + 1), 1'b0);
      putChar(8'hDC, 1'b1);
      verdict("R6 short packet", 1'b1);
    end

    // R7: partial packet then fresh SOP; result must match the second packet alone
    modeSel = 2'd1;
    putChar(8'h5C, 1'b1);
    for (int i = 0; i < 7; i++) putChar(8'(8'h90 + i), 1'b0);
    sendPkt("R7 restart", 1, 8, 77, -1, 0, 1'b0, 1'b0);
    putChar(8'h5C, 1'b1);
    for (int i = 0; i < 2; i++) putChar(8'(8'h11 * i), 1'b0);
    sendPkt("R7 restart short prefix", 1, 4, 78, -1, 0, 1'b0, 1'b0);

    // R4: no done without EOP during a long idle stretch
    for (int i = 0; i < 5; i++) begin
      putIdle();
      check("R4 no spurious done", 32'(crcDone), 32'd0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule